// File: doc/BRIEF.md
# Remote Button Serial Packet Sequencer

This block turns two active-low push buttons, one for skip-forward and one for skip-back, into timed command traffic on a single serial output line. The line normally rests low. When a button is pressed, the block raises the line for a long wake interval. It then sends asynchronous command packets for as long as that button stays held. Each packet is followed by a low pause. When the button is let go, one release packet closes the exchange.

A packet has three parts. It opens with four high bit periods. Two fixed header bytes follow, and then the command byte. Every byte is framed as one low start bit, eight data bits sent least significant bit first, and high stop bits. The command byte carries one stop bit more than the header bytes. All durations are counted in clock cycles of the system clock: the bit period, the wake interval and the inter-packet pause are parameters. The defaults give 9600 baud, a wake of about 45 ms and a pause of about 26 ms at 1.2 MHz.

Top module: `remote_seq`

## Requirements
- R1: While no exchange is in progress, `tx_line` is 0 and `busy` is 0, including during and directly after reset.
- R2: Each button input passes through two synchronizing flip-flops. A level applied before clock edge k is acted on at edge k+2, so a press seen in idle raises `tx_line` in the cycle after edge k+2.
- R3: A new exchange starts with `tx_line` held at 1 for exactly WAKE_CYC cycles.
- R4: A packet is sent as follows, with each bit lasting CYC_PER_BIT cycles:
  - 4 high bits;
  - byte 0xFF, then byte 0xFD, each as start bit 0, data bits 0..7, then two 1 stop bits;
  - the command byte in the same framing but with three stop bits.
- R5: After every packet, `tx_line` is 0 for exactly GAP_CYC cycles.
- R6: The command byte is 0xF4 when the forward button started the exchange and 0xF5 when the reverse button did.
- R7: In the last gap cycle, the block samples the synchronized level of the button that started the exchange. If that button is still pressed, the same packet is sent again, starting in the next cycle. The other button is ignored during the exchange.
- R8: If the starting button is found released at the end of a gap, one packet with command byte 0xF0 follows, then its gap, and then the block returns to idle.
- R9: If both buttons are seen pressed in the same idle cycle, the forward button wins.
- R10: `busy` is 1 from the first wake cycle through the last cycle of the release packet's gap, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fwd_btn_n | input | 1 | Forward button, low when pressed, asynchronous |
| rev_btn_n | input | 1 | Reverse button, low when pressed, asynchronous |
| tx_line | output | 1 | Serial command line, idles low |
| busy | output | 1 | High while a wake/packet/release exchange is under way |

## Verification
The bench builds the block with CYC_PER_BIT=4, WAKE_CYC=20 and GAP_CYC=12. At these values a full 38-bit packet plus its gap takes 164 cycles, so several repeats, releases that occur during the wake or during a packet, and the both-buttons case all fit in a few thousand cycles. With short windows, an off-by-one in any timer shows up as a single-cycle mismatch against the reference waveform. It does not become lost in a long interval.

// File: rtl/remote_pkg.sv
package remote_pkg;

    localparam int unsigned LEAD_BITS       = 4;
    localparam int unsigned FRAME_BITS      = 11;
    localparam int unsigned LAST_FRAME_BITS = 12;
    localparam int unsigned PKT_BITS        = LEAD_BITS + 2 * FRAME_BITS + LAST_FRAME_BITS;

    localparam logic [7:0] HDR_FIRST  = 8'hFF;
    localparam logic [7:0] HDR_SECOND = 8'hFD;
    localparam logic [7:0] CMD_FWD    = 8'hF4;
    localparam logic [7:0] CMD_REV    = 8'hF5;
    localparam logic [7:0] CMD_REL    = 8'hF0;

    localparam int unsigned BTN_FWD = 0;
    localparam int unsigned BTN_REV = 1;
    localparam int unsigned BTN_NUM = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAKE,
        ST_PKT,
        ST_GAP
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_FWD,
        SRC_REV
    } btn_src_t;

    typedef logic [PKT_BITS-1:0] pkt_vec_t;

    // One byte with start bit in position 0 and two stop bits on top.
    function automatic logic [FRAME_BITS-1:0] frame_byte(input logic [7:0] b);
        return {2'b11, b, 1'b0};
    endfunction

    // Whole packet, bit 0 leaves the line first.
    function automatic pkt_vec_t build_packet(input logic [7:0] cmd);
        pkt_vec_t v;
        v[LEAD_BITS-1:0]                                = '1;
        v[LEAD_BITS +: FRAME_BITS]                      = frame_byte(HDR_FIRST);
        v[LEAD_BITS + FRAME_BITS +: FRAME_BITS]         = frame_byte(HDR_SECOND);
        v[LEAD_BITS + 2 * FRAME_BITS +: LAST_FRAME_BITS] = {1'b1, frame_byte(cmd)};
        return v;
    endfunction

    function automatic logic is_command_code(input logic [7:0] b);
        return (b == CMD_FWD) || (b == CMD_REV) || (b == CMD_REL);
    endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] pressed
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_sync
            logic meta_q;
            logic stable_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    meta_q   <= 1'b1;
                    stable_q <= 1'b1;
                end else begin
                    meta_q   <= raw_n[i];
                    stable_q <= meta_q;
                end
            end
            assign pressed[i] = ~stable_q;
        end
    endgenerate

endmodule

// File: rtl/pkt_serializer.sv
module pkt_serializer
    import remote_pkg::*;
#(
    parameter int unsigned CYC_PER_BIT = 125
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_cmd,
    output logic       bit_out,
    output logic       done
);

    localparam int unsigned TW = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
    localparam int unsigned IW = $clog2(PKT_BITS);
    localparam logic [TW-1:0] T_LAST = TW'(CYC_PER_BIT - 1);
    localparam logic [IW-1:0] I_LAST = IW'(PKT_BITS - 1);

    pkt_vec_t      shreg;
    logic [TW-1:0] tcnt;
    logic [IW-1:0] idx;
    logic          active;

    logic bit_end;
    assign bit_end = active && (tcnt == T_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            tcnt   <= '0;
            idx    <= '0;
            active <= 1'b0;
        end else if (load) begin
            shreg  <= build_packet(load_cmd);
            tcnt   <= '0;
            idx    <= '0;
            active <= 1'b1;
        end else if (bit_end) begin
            tcnt  <= '0;
            shreg <= {1'b0, shreg[PKT_BITS-1:1]};
            if (idx == I_LAST) begin
                active <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end else if (active) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    assign bit_out = shreg[0];
    assign done    = bit_end && (idx == I_LAST);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import remote_pkg::*;
#(
    parameter int unsigned WAKE_CYC = 54000,
    parameter int unsigned GAP_CYC  = 31200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fwd_p,
    input  logic       rev_p,
    input  logic       pkt_done,
    output seq_state_t state_o,
    output logic [7:0] cmd_o,
    output logic       load,
    output logic [7:0] load_cmd
);

    localparam int unsigned MAXC = (WAKE_CYC > GAP_CYC) ? WAKE_CYC : GAP_CYC;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYC - 1);
    localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_CYC - 1);

    seq_state_t    st, st_n;
    btn_src_t      src, src_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [7:0]    cmd, cmd_n;
    logic          rel, rel_n;
    logic          held;

    always_comb begin
        case (src)
            SRC_FWD: held = fwd_p;
            SRC_REV: held = rev_p;
            default: held = 1'b0;
        endcase
    end

    always_comb begin
        st_n  = st;
        src_n = src;
        cnt_n = cnt;
        cmd_n = cmd;
        rel_n = rel;
        load  = 1'b0;
        case (st)
            ST_IDLE: begin
                cnt_n = '0;
                rel_n = 1'b0;
                if (fwd_p) begin
                    st_n  = ST_WAKE;
                    src_n = SRC_FWD;
                    cmd_n = CMD_FWD;
                end else if (rev_p) begin
                    st_n  = ST_WAKE;
                    src_n = SRC_REV;
                    cmd_n = CMD_REV;
                end
            end
            ST_WAKE: begin
                if (cnt == WAKE_LAST) begin
                    cnt_n = '0;
                    st_n  = ST_PKT;
                    load  = 1'b1;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_PKT: begin
                if (pkt_done) begin
                    st_n  = ST_GAP;
                    cnt_n = '0;
                end
            end
            ST_GAP: begin
                if (cnt == GAP_LAST) begin
                    cnt_n = '0;
                    if (rel) begin
                        st_n  = ST_IDLE;
                        src_n = SRC_NONE;
                    end else begin
                        st_n = ST_PKT;
                        load = 1'b1;
                        if (!held) begin
                            cmd_n = CMD_REL;
                            rel_n = 1'b1;
                        end
                    end
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            src <= SRC_NONE;
            cnt <= '0;
            cmd <= CMD_REL;
            rel <= 1'b0;
        end else begin
            st  <= st_n;
            src <= src_n;
            cnt <= cnt_n;
            cmd <= cmd_n;
            rel <= rel_n;
        end
    end

    assign state_o  = st;
    assign cmd_o    = cmd;
    assign load_cmd = cmd_n;

endmodule

// File: rtl/remote_seq.sv
module remote_seq
    import remote_pkg::*;
#(
    parameter int unsigned CYC_PER_BIT = 125,
    parameter int unsigned WAKE_CYC    = 54000,
    parameter int unsigned GAP_CYC     = 31200
) (
    input  logic clk,
    input  logic rst,
    input  logic fwd_btn_n,
    input  logic rev_btn_n,
    output logic tx_line,
    output logic busy
);

    logic [BTN_NUM-1:0] pressed;
    logic [BTN_NUM-1:0] raw_n;
    seq_state_t         st;
    logic [7:0]         cur_cmd;
    logic               load;
    logic [7:0]         load_cmd;
    logic               ser_bit;
    logic               ser_done;

    assign raw_n[BTN_FWD] = fwd_btn_n;
    assign raw_n[BTN_REV] = rev_btn_n;

    btn_sync #(.N(BTN_NUM)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .raw_n   (raw_n),
        .pressed (pressed)
    );

    seq_ctrl #(
        .WAKE_CYC (WAKE_CYC),
        .GAP_CYC  (GAP_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .fwd_p    (pressed[BTN_FWD]),
        .rev_p    (pressed[BTN_REV]),
        .pkt_done (ser_done),
        .state_o  (st),
        .cmd_o    (cur_cmd),
        .load     (load),
        .load_cmd (load_cmd)
    );

    pkt_serializer #(.CYC_PER_BIT(CYC_PER_BIT)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_cmd (load_cmd),
        .bit_out  (ser_bit),
        .done     (ser_done)
    );

    always_comb begin
        case (st)
            ST_WAKE: tx_line = 1'b1;
            ST_PKT:  tx_line = ser_bit;
            default: tx_line = 1'b0;
        endcase
    end

    assign busy = (st != ST_IDLE);

endmodule

// File: rtl/remote_seq_chk.sv
module remote_seq_chk
    import remote_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               tx_line,
    input logic               busy,
    input logic [BTN_NUM-1:0] pressed,
    input logic [7:0]         cmd
);

    a_r1_idle_line_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tx_line);

    a_r3_wake_opens_high: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> tx_line);

    a_r2_press_precedes_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(|pressed));

    a_r5_gap_ends_low: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(!tx_line));

    a_r6_cmd_legal: assert property (@(posedge clk) disable iff (rst)
        busy |-> is_command_code(cmd));

    a_r8_exit_after_release: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(cmd) == CMD_REL);

    a_r9_fwd_wins: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && $past(pressed[BTN_FWD])) |-> cmd == CMD_FWD);

endmodule

bind remote_seq remote_seq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tx_line (tx_line),
    .busy    (busy),
    .pressed (pressed),
    .cmd     (cur_cmd)
);

// File: tb/tb_remote_seq.sv
module tb_remote_seq;

    localparam int CPB  = 4;
    localparam int WAKE = 20;
    localparam int GAP  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fwd_n = 1'b1;
    logic rev_n = 1'b1;
    logic tx_line;
    logic busy;

    always #10 clk = ~clk;

    remote_seq #(
        .CYC_PER_BIT (CPB),
        .WAKE_CYC    (WAKE),
        .GAP_CYC     (GAP)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .fwd_btn_n (fwd_n),
        .rev_btn_n (rev_n),
        .tx_line   (tx_line),
        .busy      (busy)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit finished = 0;

    // reference waveform: expected tx per future cycle, requirement tag, gap-end flag
    bit qtx[$];
    int qreq[$];
    bit qlast[$];

    bit        f1 = 1, f2 = 1, r1 = 1, r2 = 1;
    logic [7:0] mcmd = 8'h00;
    int        msrc = 0;
    bit        mrel = 0;

    task automatic check(input string what, input int req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s cycle=%0d actual=%0b expected=%0b", req, what, cyc, act, exp);
        end
    endtask

    task automatic push_bits(input bit v, input int n, input int req);
        repeat (n) begin
            qtx.push_back(v);
            qreq.push_back(req);
            qlast.push_back(1'b0);
        end
    endtask

    task automatic push_byte(input logic [7:0] b, input int stops, input int req);
        push_bits(1'b0, CPB, req);
        for (int i = 0; i < 8; i++) push_bits(b[i], CPB, req);
        push_bits(1'b1, CPB * stops, req);
    endtask

    // R4 packet layout, command byte tagged R6/R7/R8, trailing gap R5
    task automatic push_packet(input logic [7:0] cmd, input int creq);
        push_bits(1'b1, 4 * CPB, 4);
        push_byte(8'hFF, 2, 4);
        push_byte(8'hFD, 2, 4);
        push_byte(cmd, 3, creq);
        push_bits(1'b0, GAP - 1, 5);
        qtx.push_back(1'b0);
        qreq.push_back(5);
        qlast.push_back(1'b1);
    endtask

    task automatic step(input logic f, input logic r);
        bit etx, ebz, elast;
        int ereq;
        @(negedge clk);
        fwd_n = f;
        rev_n = r;
        cyc++;
        if (qtx.size() == 0) begin
            etx = 1'b0; ebz = 1'b0; ereq = 1; elast = 1'b0;   // R1 idle
        end else begin
            etx = qtx.pop_front(); ereq = qreq.pop_front(); elast = qlast.pop_front();
            ebz = 1'b1;
        end
        check("tx_line", ereq, tx_line, etx);
        check("busy", (ereq == 1) ? 1 : 10, busy, ebz);        // R10
        if (ebz == 1'b0) begin
            // R2: decision uses level from two edges back; R9: forward first
            if (!f2) begin
                mcmd = 8'hF4; msrc = 0; mrel = 0;
                push_bits(1'b1, WAKE, 3);
                push_packet(mcmd, 6);
            end else if (!r2) begin
                mcmd = 8'hF5; msrc = 1; mrel = 0;
                push_bits(1'b1, WAKE, 3);
                push_packet(mcmd, 6);
            end
        end else if (elast && !mrel) begin
            if ((msrc == 0) ? !f2 : !r2) begin
                push_packet(mcmd, 7);                          // R7 repeat
            end else begin
                mrel = 1;
                push_packet(8'hF0, 8);                         // R8 release
            end
        end
        f2 = f1; f1 = f;
        r2 = r1; r1 = r;
    endtask

    task automatic run(input int n, input logic f, input logic r);
        repeat (n) step(f, r);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check("reset tx", 1, tx_line, 1'b0);                  // R1
        check("reset busy", 1, busy, 1'b0);                   // R1
        rst = 1'b0;
        run(10, 1, 1);
        // forward held across two packets, then released (R6, R7, R8)
        run(300, 0, 1);
        run(400, 1, 1);
        // reverse released during wake: one F5 then release (R6, R8)
        run(15, 1, 0);
        run(500, 1, 1);
        // both pressed together: forward wins (R9)
        run(200, 0, 0);
        run(400, 1, 1);
        // forward held, reverse pressed meanwhile is ignored (R7)
        run(100, 0, 1);
        run(250, 0, 0);
        run(500, 1, 1);
        // short glitch still caught by synchronizer (R2)
        run(2, 0, 1);
        run(400, 1, 1);
        check("idle at end", 1, busy, 1'b0);                  // R1
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired cycle=%0d actual=running expected=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule